// File: doc/BRIEF.md
# Power Path Break-Before-Make Sequencer

This controller chooses whether the system load draws from the adapter or from the battery. It drives two switch enables and never turns both on together. Its inputs are logic flags from analog comparators: adapter present, adapter voltage at least the required margin (300 mV) above the battery, input overvoltage, input undervoltage, and system rail near the battery voltage. Its outputs are an adapter-switch enable, a battery-switch enable and a sleep indicator. All three outputs come straight from flip-flops, so they cannot glitch.

After reset, and whenever it is asleep, the block keeps the battery switch closed. When a qualified adapter shows enough margin, the block opens the battery switch. It then waits a fixed dead window, counted in clock cycles, with both switches open, and only then closes the adapter switch. If the adapter is lost or disqualified during that window, the block aborts straight back to the battery. If the adapter is lost or disqualified while it is feeding the system, the adapter switch opens on the next edge and the block enters sleep. The battery switch stays open until the system rail has fallen close to the battery voltage.

Top module: `pwrpath_seq`

## Requirements
- R1: After reset, bat_sw_en is 1, adp_sw_en is 0 and sleep is 1.
- R2: adp_sw_en and bat_sw_en are never 1 in the same cycle.
- R3: While on the battery path, the block leaves sleep only when adp_present=1, margin_ok=1, in_ovp=0 and in_uvp=0 at a clock edge. At that edge both enables go to 0 and sleep goes to 0.
- R4: adp_sw_en rises exactly DEAD_CYC clock cycles after both enables went to 0 on leaving sleep. Both enables stay 0 throughout those cycles.
- R5: During the dead window, adp_present=0, in_ovp=1 or in_uvp=1 at an edge returns the outputs at that edge to bat_sw_en=1, adp_sw_en=0 and sleep=1.
- R6: While on the adapter path, adp_present=0 at an edge drives adp_sw_en to 0 and sleep to 1 at that edge. Loss of margin_ok alone does not leave the adapter path.
- R7: After the adapter path is left, bat_sw_en stays 0 until sys_near_batt=1 is seen at an edge. At that edge bat_sw_en becomes 1.
- R8: in_ovp=1 or in_uvp=1 opens the adapter switch exactly like removal does. Either flag also blocks leaving sleep.
- R9: Outputs change only at rising clock edges. An input change between edges is not visible on the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adp_present | input | 1 | Adapter detected |
| margin_ok | input | 1 | Adapter voltage is above battery by the required margin |
| in_ovp | input | 1 | Input overvoltage flag |
| in_uvp | input | 1 | Input undervoltage flag |
| sys_near_batt | input | 1 | System rail has dropped close to battery voltage |
| adp_sw_en | output | 1 | Adapter switch enable (registered) |
| bat_sw_en | output | 1 | Battery switch enable (registered) |
| sleep | output | 1 | Sleep indicator (registered) |

## Verification
The assertions check on every cycle that the two enables are never on together. They also check that every rise of the adapter enable follows at least the full dead window with both enables off. Further cycle-by-cycle checks cover staying on the battery without a qualified adapter, opening the adapter switch on removal or fault, and holding the battery switch open until the system rail has come down. Some behaviour only the bench's scenarios can show: the exact cycle the adapter switch closes, aborts at chosen points inside the dead window, the fact that margin loss alone is ignored on the adapter path, and that a mid-cycle input change does not reach the outputs.

// File: rtl/pwrpath_pkg.sv
package pwrpath_pkg;

    typedef enum logic [1:0] {
        PP_BATT = 2'd0,   // battery feeds system, asleep
        PP_DEAD = 2'd1,   // both switches open, counting dead window
        PP_ADP  = 2'd2,   // adapter feeds system
        PP_RET  = 2'd3    // both open, waiting for system rail to fall
    } pp_state_e;

    typedef struct packed {
        pp_state_e state;
        logic      adp;
        logic      bat;
        logic      slp;
    } pp_regs_t;

endpackage

// File: rtl/pwrpath_qual.sv
module pwrpath_qual (
    input  logic adp_present,
    input  logic margin_ok,
    input  logic in_ovp,
    input  logic in_uvp,
    output logic go,
    output logic lost
);
    logic fault;

    always_comb begin
        fault = in_ovp | in_uvp;
        go    = adp_present & margin_ok & ~fault;
        lost  = ~adp_present | fault;
    end
endmodule

// File: rtl/pwrpath_deadtimer.sv
module pwrpath_deadtimer #(
    parameter int DEAD_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = (cnt_q == LAST);
        cnt_d = '0;
        if (run) begin
            cnt_d = done ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pwrpath_chk.sv
module pwrpath_chk #(
    parameter int DEAD_CYC = 2500
) (
    input logic clk,
    input logic rst_n,
    input logic adp_present,
    input logic margin_ok,
    input logic in_ovp,
    input logic in_uvp,
    input logic sys_near_batt,
    input logic adp_sw_en,
    input logic bat_sw_en,
    input logic sleep
);
    logic [31:0] off_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cnt <= '0;
        end else if (!adp_sw_en && !bat_sw_en) begin
            if (off_cnt < 32'(DEAD_CYC)) off_cnt <= off_cnt + 1;
        end else begin
            off_cnt <= '0;
        end
    end

    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(adp_sw_en && bat_sw_en));

    a_r3_stay_on_batt: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sw_en && !(adp_present && margin_ok && !in_ovp && !in_uvp)) |=> bat_sw_en);

    a_r4_dead_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adp_sw_en) |-> (off_cnt >= 32'(DEAD_CYC)));

    a_r6_removal_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_sw_en && !adp_present) |=> (!adp_sw_en && sleep));

    a_r8_fault_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_sw_en && (in_ovp || in_uvp)) |=> !adp_sw_en);

    a_r7_bat_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !bat_sw_en && !sys_near_batt) |=> !bat_sw_en);

    a_r6_sleep_adp_off: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !adp_sw_en);
endmodule

bind pwrpath_seq pwrpath_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .adp_present   (adp_present),
    .margin_ok     (margin_ok),
    .in_ovp        (in_ovp),
    .in_uvp        (in_uvp),
    .sys_near_batt (sys_near_batt),
    .adp_sw_en     (adp_sw_en),
    .bat_sw_en     (bat_sw_en),
    .sleep         (sleep)
);

// File: rtl/pwrpath_seq.sv
module pwrpath_seq
    import pwrpath_pkg::*;
#(
    parameter int DEAD_CYC = 2500   // 10 us at 250 MHz
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adp_present,
    input  logic margin_ok,
    input  logic in_ovp,
    input  logic in_uvp,
    input  logic sys_near_batt,
    output logic adp_sw_en,
    output logic bat_sw_en,
    output logic sleep
);
    localparam pp_regs_t RST_REGS = '{state: PP_BATT, adp: 1'b0, bat: 1'b1, slp: 1'b1};

    pp_regs_t regs_d, regs_q;
    logic     go, lost, dead_done, dead_run;

    pwrpath_qual u_qual (
        .adp_present (adp_present),
        .margin_ok   (margin_ok),
        .in_ovp      (in_ovp),
        .in_uvp      (in_uvp),
        .go          (go),
        .lost        (lost)
    );

    assign dead_run = (regs_q.state == PP_DEAD);

    pwrpath_deadtimer #(.DEAD_CYC(DEAD_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dead_run),
        .done  (dead_done)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            PP_BATT: begin
                if (go) begin
                    regs_d = '{state: PP_DEAD, adp: 1'b0, bat: 1'b0, slp: 1'b0};
                end
            end
            PP_DEAD: begin
                if (lost) begin
                    regs_d = RST_REGS;
                end else if (dead_done) begin
                    regs_d = '{state: PP_ADP, adp: 1'b1, bat: 1'b0, slp: 1'b0};
                end
            end
            PP_ADP: begin
                if (lost) begin
                    regs_d = '{state: PP_RET, adp: 1'b0, bat: 1'b0, slp: 1'b1};
                end
            end
            PP_RET: begin
                if (sys_near_batt) begin
                    regs_d = RST_REGS;
                end
            end
            default: regs_d = RST_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RST_REGS;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign adp_sw_en = regs_q.adp;
    assign bat_sw_en = regs_q.bat;
    assign sleep     = regs_q.slp;
endmodule

// File: tb/test_pwrpath_seq.sv
module test_pwrpath_seq;
    localparam int DC = 40;

    typedef struct {
        logic  adp;
        logic  bat;
        logic  slp;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adp_present = 1'b0, margin_ok = 1'b0, in_ovp = 1'b0, in_uvp = 1'b0;
    logic sys_near_batt = 1'b0;
    logic adp_sw_en, bat_sw_en, sleep;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    pwrpath_seq #(.DEAD_CYC(DC)) i_pwrpath_seq (
        .clk(clk), .rst_n(rst_n), .adp_present(adp_present), .margin_ok(margin_ok),
        .in_ovp(in_ovp), .in_uvp(in_uvp), .sys_near_batt(sys_near_batt),
        .adp_sw_en(adp_sw_en), .bat_sw_en(bat_sw_en), .sleep(sleep)
    );

    task automatic cmp(input exp_t e);
        checks++;
        if ({adp_sw_en, bat_sw_en, sleep} !== {e.adp, e.bat, e.slp}) begin
            errors++;
            $display("FAIL %s: adp/bat/sleep actual %b%b%b expected %b%b%b",
                     e.tag, adp_sw_en, bat_sw_en, sleep, e.adp, e.bat, e.slp);
        end
    endtask

    // monitor: compares one expected item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) cmp(q.pop_front());
        end
    end

    // driver: apply inputs at negedge, push what the next edge must produce
    task automatic step(input logic p, input logic m, input logic ov, input logic uv,
                        input logic nr, input logic ea, input logic eb, input logic es,
                        input string tag);
        exp_t e;
        @(negedge clk);
        adp_present = p; margin_ok = m; in_ovp = ov; in_uvp = uv; sys_near_batt = nr;
        e.adp = ea; e.bat = eb; e.slp = es; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic go_to_adapter();
        step(1, 1, 0, 0, 0, 0, 0, 0, "R3 leave sleep");
        for (int i = 1; i < DC; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R4 dead window");
        step(1, 1, 0, 0, 0, 1, 0, 0, "R4 adapter on");
    endtask

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.adp = 0; r.bat = 1; r.slp = 1; r.tag = "R1 reset state";
        cmp(r);
        rst_n = 1'b1;

        step(1, 0, 0, 0, 0, 0, 1, 1, "R3 no margin stays asleep");
        step(0, 1, 0, 0, 0, 0, 1, 1, "R3 absent stays asleep");
        step(1, 1, 1, 0, 0, 0, 1, 1, "R8 overvoltage blocks exit");
        step(1, 1, 0, 1, 0, 0, 1, 1, "R8 undervoltage blocks exit");

        go_to_adapter();
        step(1, 0, 0, 0, 0, 1, 0, 0, "R6 margin loss ignored");
        step(1, 0, 0, 0, 1, 1, 0, 0, "R6 stays on adapter");

        // R9: removal mid-cycle must not show before the next edge
        @(negedge clk);
        adp_present = 0; margin_ok = 0; sys_near_batt = 0;
        #1;
        r.adp = 1; r.bat = 0; r.slp = 0; r.tag = "R9 no change between edges";
        cmp(r);
        r.adp = 0; r.bat = 0; r.slp = 1; r.tag = "R6 removal opens adapter";
        q.push_back(r);

        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 1, "R7 battery waits");
        step(0, 0, 0, 0, 1, 0, 1, 1, "R7 battery closes");

        // abort by removal inside dead window
        step(1, 1, 0, 0, 0, 0, 0, 0, "R3 leave sleep");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R4 dead window");
        step(0, 1, 0, 0, 0, 0, 1, 1, "R5 removal aborts");

        // abort by fault inside dead window
        step(1, 1, 0, 0, 0, 0, 0, 0, "R3 leave sleep");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R4 dead window");
        step(1, 1, 1, 0, 0, 0, 1, 1, "R5 fault aborts");

        // abort on the last dead cycle: timer must restart
        step(1, 1, 0, 0, 0, 0, 0, 0, "R3 leave sleep");
        for (int i = 1; i < DC; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R4 dead window");
        step(1, 1, 0, 1, 0, 0, 1, 1, "R5 late fault aborts");

        go_to_adapter();
        step(1, 1, 1, 0, 0, 0, 0, 1, "R8 overvoltage opens adapter");
        step(1, 1, 1, 0, 0, 0, 0, 1, "R7 battery waits after fault");
        step(1, 1, 1, 0, 1, 0, 1, 1, "R7 battery closes after fault");
        step(1, 1, 1, 0, 0, 0, 1, 1, "R8 fault keeps sleep");

        go_to_adapter();
        step(1, 1, 0, 1, 0, 0, 0, 1, "R8 undervoltage opens adapter");
        step(0, 0, 0, 0, 1, 0, 1, 1, "R7 battery closes");

        wait (q.size() == 0);
        @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule